// File: doc/BRIEF.md
# Two-level I/O address decoder

This block decodes a processor's memory-mapped I/O window and returns read data from the addressed peripheral. It takes one I/O access strobe and the 32-bit address. It drives one-hot select strobes for two classes of peripheral: extended devices and ordinary devices. It also picks 32-bit read data from the addressed slot and folds the peripherals' active-low wait lines into one ready signal. Finally, it packs the peripherals' interrupt lines into a 32-bit system interrupt vector, together with constant masks that give the trigger type and mark the unused bits.

The decode has two levels. An extended-device field in the address selects one of 2^XBITS slots. The highest slot is not a device: it opens a second field that selects one of 2^OBITS ordinary-device slots. The device population comes from a single ordered list of device classes. Each class has an instance count, a flag that places it among the extended devices, an interrupt count and a bit-per-line edge mask. Slot numbers, interrupt positions and the edge mask all follow from that list. Elaboration stops with an error in any of these cases:
- there are more ordinary devices than ordinary slots;
- there are more extended devices than 2^XBITS − 1;
- the interrupts need more than 32 bits;
- a class has more interrupt lines than MAXI.

The block is purely combinational. Inputs for slots that the list does not populate are ignored.

Top module: `io_window_decode`

## Requirements
- R1: With `io_sel` high, `xsel` has exactly one bit set: the bit numbered by the extended field `addr[XSHIFT+XBITS-1:XSHIFT]` (bits 13:12 by default).
- R2: With `io_sel` high and the extended field all ones, `osel` has exactly the bit numbered by the ordinary field `addr[OSHIFT+OBITS-1:OSHIFT]` set (bits 10:8 by default). Otherwise `osel` is zero.
- R3: With `io_sel` low, `xsel` and `osel` are all zero, whatever the address.
- R4: When the extended field is below the number of extended devices, `rdata` equals slot k of `rd_xd` (bits k*32+31:k*32), where k is the field value.
- R5: When the extended field is all ones and the ordinary field k is below the number of ordinary devices, `rdata` equals slot k of `rd_ord` (bits k*32+31:k*32).
- R6: A read from an unpopulated slot at either level returns zero.
- R7: `wait_n` is the AND of the wait lines of populated slots only. A low wait line on an unpopulated slot has no effect, and `wait_n` is 1 when no devices exist.
- R8: `sys_irq` bits 0 to NSYS-1 carry `irq_sys`. Device lines follow in class-list order, instance-major and line-minor, with each instance taking NIRQ consecutive bits. Line i of ordinary device k is `irq_ord[k*MAXI+i]`, and line i of extended device k is `irq_xd[k*MAXI+i]`. Devices are numbered within their own kind in list order.
- R9: Bits of `sys_irq` at or above the total interrupt count are 0. `irq_unused` has a 1 exactly at those bits.
- R10: `irq_edge` has a 1 at the vector position of each interrupt line whose bit in its class edge mask is 1, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_sel | input | 1 | I/O access strobe |
| addr | input | 32 | Processor address |
| rd_ord | input | 2^OBITS*32 | Read data, one 32-bit slot per ordinary device |
| rd_xd | input | (2^XBITS-1)*32 | Read data, one 32-bit slot per extended device |
| wt_ord_n | input | 2^OBITS | Active-low wait per ordinary slot |
| wt_xd_n | input | 2^XBITS-1 | Active-low wait per extended slot |
| irq_sys | input | NSYS | System-level interrupt lines |
| irq_ord | input | 2^OBITS*MAXI | Interrupt lines, MAXI per ordinary slot |
| irq_xd | input | (2^XBITS-1)*MAXI | Interrupt lines, MAXI per extended slot |
| xsel | output | 2^XBITS | Extended-level select strobes |
| osel | output | 2^OBITS | Ordinary-level select strobes |
| rdata | output | 32 | Selected read data |
| wait_n | output | 1 | Combined active-low wait |
| sys_irq | output | 32 | Packed interrupt vector |
| irq_edge | output | 32 | Constant edge-type mask |
| irq_unused | output | 32 | Constant mask of unused vector bits |

## Verification
The embedded assertions check on every evaluation that:
- the selects are zero while the strobe is low;
- each select vector holds at most one bit, and exactly one extended bit while the strobe is high;
- an ordinary select appears only under the top extended slot;
- no unused interrupt bit is ever driven.

Only the bench scenarios can show the rest against a list-derived model:
- that the chosen slot matches the address field;
- that read data comes from the right slot, and is zero for empty slots;
- that wait lines on unpopulated slots are ignored;
- that each interrupt line lands at the right vector bit with the right edge type.

// File: rtl/io_window_decode.sv
module io_window_decode #(
  parameter int XBITS  = 2,
  parameter int XSHIFT = 12,
  parameter int OBITS  = 3,
  parameter int OSHIFT = 8,
  parameter int NSYS   = 2,
  parameter int MAXI   = 4,
  parameter int NCLS   = 5,
  parameter int CLS_CNT  [NCLS] = '{2, 1, 2, 3, 1},
  parameter bit CLS_XD   [NCLS] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
  parameter int CLS_NIRQ [NCLS] = '{1, 2, 1, 0, 3},
  parameter int CLS_EDGE [NCLS] = '{0, 1, 1, 0, 5}
) (
  input  logic                                io_sel,
  input  logic [31:0]                         addr,
  input  logic [(2**OBITS)*32-1:0]            rd_ord,
  input  logic [((2**XBITS)-1)*32-1:0]        rd_xd,
  input  logic [(2**OBITS)-1:0]               wt_ord_n,
  input  logic [(2**XBITS)-2:0]               wt_xd_n,
  input  logic [NSYS-1:0]                     irq_sys,
  input  logic [(2**OBITS)*MAXI-1:0]          irq_ord,
  input  logic [((2**XBITS)-1)*MAXI-1:0]      irq_xd,
  output logic [(2**XBITS)-1:0]               xsel,
  output logic [(2**OBITS)-1:0]               osel,
  output logic [31:0]                         rdata,
  output logic                                wait_n,
  output logic [31:0]                         sys_irq,
  output logic [31:0]                         irq_edge,
  output logic [31:0]                         irq_unused
);

  localparam int XSLOTS = 2**XBITS;
  localparam int OSLOTS = 2**OBITS;
  localparam int XTOP   = XSLOTS - 1;

  function automatic int dev_total(bit want_xd);
    int n = 0;
    for (int c = 0; c < NCLS; c++)
      if (CLS_XD[c] == want_xd) n += CLS_CNT[c];
    return n;
  endfunction

  function automatic int dev_first(int cls);
    int n = 0;
    for (int c = 0; c < cls; c++)
      if (CLS_XD[c] == CLS_XD[cls]) n += CLS_CNT[c];
    return n;
  endfunction

  function automatic int irq_first(int cls);
    int n = NSYS;
    for (int c = 0; c < cls; c++) n += CLS_CNT[c] * CLS_NIRQ[c];
    return n;
  endfunction

  function automatic int irq_widest();
    int n = 0;
    for (int c = 0; c < NCLS; c++)
      if (CLS_NIRQ[c] > n) n = CLS_NIRQ[c];
    return n;
  endfunction

  function automatic logic [31:0] edge_vec();
    logic [31:0] v = '0;
    for (int c = 0; c < NCLS; c++)
      for (int d = 0; d < CLS_CNT[c]; d++)
        for (int i = 0; i < CLS_NIRQ[c]; i++)
          if (((CLS_EDGE[c] >> i) & 1) == 1)
            v[irq_first(c) + d*CLS_NIRQ[c] + i] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] unused_vec(int used);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) v[b] = (b >= used);
    return v;
  endfunction

  function automatic logic [OSLOTS-1:0] ord_pop_vec(int n);
    logic [OSLOTS-1:0] v = '0;
    for (int k = 0; k < OSLOTS; k++) v[k] = (k < n);
    return v;
  endfunction

  function automatic logic [XSLOTS-2:0] xd_pop_vec(int n);
    logic [XSLOTS-2:0] v = '0;
    for (int k = 0; k < XSLOTS-1; k++) v[k] = (k < n);
    return v;
  endfunction

  localparam int NORD   = dev_total(1'b0);
  localparam int NXD    = dev_total(1'b1);
  localparam int NIRQ_T = irq_first(NCLS);
  localparam logic [OSLOTS-1:0] ORD_POP = ord_pop_vec(NORD);
  localparam logic [XSLOTS-2:0] XD_POP  = xd_pop_vec(NXD);

  if (XBITS < 1 || NSYS < 1)
    $error("io_window_decode: XBITS and NSYS must be at least 1");
  if (NORD > OSLOTS)
    $error("io_window_decode: %0d ordinary devices exceed %0d slots", NORD, OSLOTS);
  if (NXD > XSLOTS - 1)
    $error("io_window_decode: %0d extended devices exceed %0d slots", NXD, XSLOTS - 1);
  if (NIRQ_T > 32)
    $error("io_window_decode: %0d interrupt lines exceed 32", NIRQ_T);
  if (irq_widest() > MAXI)
    $error("io_window_decode: a class has more than MAXI interrupt lines");

  logic [XBITS-1:0] xf;
  logic [OBITS-1:0] of;

  assign xf = addr[XSHIFT +: XBITS];
  assign of = addr[OSHIFT +: OBITS];

  assign xsel = {{(XSLOTS-1){1'b0}}, io_sel} << xf;
  assign osel = {{(OSLOTS-1){1'b0}}, xsel[XTOP]} << of;

  always_comb begin
    rdata = '0;
    if (xf == XBITS'(XTOP)) begin
      for (int k = 0; k < OSLOTS; k++)
        if (k < NORD && of == OBITS'(k)) rdata = rd_ord[k*32 +: 32];
    end else begin
      for (int k = 0; k < XSLOTS-1; k++)
        if (k < NXD && xf == XBITS'(k)) rdata = rd_xd[k*32 +: 32];
    end
  end

  assign wait_n = (&(wt_ord_n | ~ORD_POP)) & (&(wt_xd_n | ~XD_POP));

  always_comb begin
    sys_irq = '0;
    for (int s = 0; s < NSYS; s++) sys_irq[s] = irq_sys[s];
    for (int c = 0; c < NCLS; c++)
      for (int d = 0; d < CLS_CNT[c]; d++)
        for (int i = 0; i < CLS_NIRQ[c]; i++)
          if (CLS_XD[c])
            sys_irq[irq_first(c) + d*CLS_NIRQ[c] + i] = irq_xd[(dev_first(c)+d)*MAXI + i];
          else
            sys_irq[irq_first(c) + d*CLS_NIRQ[c] + i] = irq_ord[(dev_first(c)+d)*MAXI + i];
  end

  assign irq_edge   = edge_vec();
  assign irq_unused = unused_vec(NIRQ_T);

  always_comb begin
    p_sel_idle_r3: assert (io_sel || (xsel == '0 && osel == '0))
      else $error("selects active while strobe low");
    p_xsel_onehot_r1: assert ($onehot0(xsel) && (!io_sel || $countones(xsel) == 1))
      else $error("extended select not one-hot");
    p_osel_nested_r2: assert ($onehot0(osel) && (osel == '0 || (io_sel && xsel[XTOP])))
      else $error("ordinary select outside top extended slot");
    p_irq_spare_zero_r9: assert ((sys_irq & irq_unused) == '0)
      else $error("unused interrupt bit driven");
  end

endmodule

// File: tb/tb_io_window_decode.sv
module tb_io_window_decode;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          io_sel;
  logic [31:0]   addr;
  logic [255:0]  rd_ord;
  logic [95:0]   rd_xd;
  logic [7:0]    wt_ord_n;
  logic [2:0]    wt_xd_n;
  logic [1:0]    irq_sys;
  logic [31:0]   irq_ord;
  logic [11:0]   irq_xd;
  logic [3:0]    xsel;
  logic [7:0]    osel;
  logic [31:0]   rdata;
  logic          wait_n;
  logic [31:0]   sys_irq, irq_edge, irq_unused;

  io_window_decode dut (.*);

  int n_chk = 0, n_bad = 0;
  int b_cnt [5] = '{2, 1, 2, 3, 1};
  bit b_xd  [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  int b_ni  [5] = '{1, 2, 1, 0, 3};
  int b_edg [5] = '{0, 1, 1, 0, 5};
  logic [31:0] od [8];
  logic [31:0] xd [3];

  task automatic chk(string req, logic [255:0] got, logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic load_data();
    for (int k = 0; k < 8; k++) begin od[k] = $urandom; rd_ord[k*32 +: 32] = od[k]; end
    for (int k = 0; k < 3; k++) begin xd[k] = $urandom; rd_xd[k*32 +: 32] = xd[k]; end
  endtask

  function automatic logic [3:0] exp_xsel();
    return io_sel ? 4'(1) << addr[13:12] : 4'd0;
  endfunction

  function automatic logic [7:0] exp_osel();
    return (io_sel && addr[13:12] == 2'd3) ? 8'(1) << addr[10:8] : 8'd0;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (addr[13:12] == 2'd3) return (addr[10:8] < 6) ? od[addr[10:8]] : 32'd0;
    return xd[addr[13:12]];
  endfunction

  function automatic logic [31:0] exp_irq(int mode);
    logic [31:0] v = '0, e = '0;
    int idx = 2, o = 0, x = 0;
    v[1:0] = irq_sys;
    for (int c = 0; c < 5; c++)
      for (int d = 0; d < b_cnt[c]; d++) begin
        for (int i = 0; i < b_ni[c]; i++) begin
          v[idx] = b_xd[c] ? irq_xd[x*4+i] : irq_ord[o*4+i];
          e[idx] = b_edg[c][i];
          idx++;
        end
        if (b_xd[c]) x++; else o++;
      end
    if (mode == 0) return v;
    if (mode == 1) return e;
    return ~((32'd1 << idx) - 32'd1);
  endfunction

  function automatic logic [31:0] base_x(int k);
    return ((32'(k) | (~32'd0 << 2)) << 12);
  endfunction

  function automatic logic [31:0] base_o(int k);
    return ((32'(k) | (~32'd0 << 3)) << 8);
  endfunction

  task automatic check_decode(string tag);
    @(posedge clk); #1;
    chk({tag, " R1 xsel"}, 256'(xsel), 256'(exp_xsel()));
    chk({tag, " R2 osel"}, 256'(osel), 256'(exp_osel()));
    chk({tag, " R4/R5/R6 rdata"}, 256'(rdata), 256'(exp_rdata()));
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d0c0de));
    io_sel = 0; addr = '0; wt_ord_n = '1; wt_xd_n = '1;
    irq_sys = '0; irq_ord = '0; irq_xd = '0;
    load_data();

    // R3: strobe low, any address
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); addr = $urandom; io_sel = 0;
      @(posedge clk); #1;
      chk("R3 xsel idle", 256'(xsel), 0);
      chk("R3 osel idle", 256'(osel), 0);
    end

    // R1/R4: extended slots at their bases
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); io_sel = 1; addr = base_x(k); load_data();
      @(posedge clk); #1;
      chk("R1 xsel sweep", 256'(xsel), 256'(4'(1) << k));
      chk("R2 osel off", 256'(osel), 0);
      chk("R4 rdata sweep", 256'(rdata), 256'(xd[k]));
    end

    // R2/R5/R6: ordinary slots, including empty slots 6 and 7
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); io_sel = 1; addr = base_o(k); load_data();
      @(posedge clk); #1;
      chk("R1 xsel top", 256'(xsel), 256'(4'b1000));
      chk("R2 osel sweep", 256'(osel), 256'(8'(1) << k));
      chk(k < 6 ? "R5 rdata sweep" : "R6 rdata empty", 256'(rdata),
          256'(k < 6 ? od[k] : 32'd0));
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      @(negedge clk); io_sel = 1'($urandom); addr = $urandom;
      if (n % 3 == 0) addr[13:12] = 2'd3;
      load_data();
      check_decode("rand");
    end

    // R7: combined wait
    @(negedge clk); wt_ord_n = '1; wt_xd_n = '1;
    @(posedge clk); #1; chk("R7 wait all high", 256'(wait_n), 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); wt_ord_n = ~(8'(1) << k); wt_xd_n = '1;
      @(posedge clk); #1; chk("R7 wait ordinary", 256'(wait_n), 256'(k >= 6));
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); wt_ord_n = '1; wt_xd_n = ~(3'(1) << k);
      @(posedge clk); #1; chk("R7 wait extended", 256'(wait_n), 0);
    end
    for (int n = 0; n < 50; n++) begin
      @(negedge clk); wt_ord_n = 8'($urandom) | 8'h3f; wt_xd_n = 3'($urandom);
      if (n % 2 == 0) wt_ord_n = $urandom;
      @(posedge clk); #1;
      chk("R7 wait rand", 256'(wait_n), 256'((&wt_ord_n[5:0]) & (&wt_xd_n)));
    end

    // R8/R9: interrupt packing
    for (int n = 0; n < 100; n++) begin
      @(negedge clk); irq_sys = $urandom; irq_ord = $urandom; irq_xd = $urandom;
      @(posedge clk); #1;
      chk("R8 irq pack", 256'(sys_irq), 256'(exp_irq(0)));
      chk("R9 irq spare", 256'(sys_irq & irq_unused), 0);
    end
    for (int b = 0; b < 32; b++) begin
      @(negedge clk); irq_sys = '0; irq_ord = 32'(1) << b; irq_xd = '0;
      @(posedge clk); #1; chk("R8 irq walk ordinary", 256'(sys_irq), 256'(exp_irq(0)));
    end
    for (int b = 0; b < 12; b++) begin
      @(negedge clk); irq_ord = '0; irq_xd = 12'(1) << b;
      @(posedge clk); #1; chk("R8 irq walk extended", 256'(sys_irq), 256'(exp_irq(0)));
    end

    // R9/R10: constant masks
    chk("R10 edge mask", 256'(irq_edge), 256'(exp_irq(1)));
    chk("R10 edge literal", 256'(irq_edge), 256'(32'h000005d0));
    chk("R9 unused mask", 256'(irq_unused), 256'(exp_irq(2)));
    chk("R9 unused literal", 256'(irq_unused), 256'(32'hfffff800));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule